// File: doc/BRIEF.md
# Two-Stage Serial Rate Clock-Enable Generator

This block derives the timing strobes for a serial port's transmitter and receiver from a single reference clock, nominally 24 MHz. The reference is first divided by a small prescale factor, picked through a 2-bit select code, and then by a 16-bit divisor that the host loads one byte at a time. The result is a one-cycle strobe at sixteen times the serial bit rate, which is the sampling rate for the receiver. A further divide-by-16 gives the bit-rate strobe that the transmitter uses. Both channels take the same pair of strobes, so they always run at the same rate.

New divisor bytes and a new prescale code go first into holding registers. The running counters take them only at the end of the current 16x period, so a change never produces a short or stretched period. For test, the 16x strobe can be driven onto a separate output, but only while an enable input is high.

There is no data stream at this block's edge. Register writes are single-cycle strobes that are always accepted, and the outputs are plain enables with no handshake, so no back-pressure rules apply.

Top module: `baud_clock_gen`

## Requirements
- R1: While reset is asserted all three outputs are low. Reset leaves divisor 1 and prescale code 0 in force, so the first 16x strobe is high in the 13th clock cycle counted from the cycle in which reset is released.
- R2: The prescale select is a 2-bit code. Code 0 divides by 13, code 1 by 1, code 2 by 6 and code 3 by 8.
- R3: The divisor is the low byte (written when `div_lo_we` is high) joined with the high byte (written when `div_hi_we` is high), both taken from `div_wdata`. The 16x strobe repeats every prescale × divisor clock cycles.
- R4: A divisor of 0 behaves exactly like a divisor of 1.
- R5: The bit-rate strobe is high only in a cycle in which the 16x strobe is also high. It is high on every 16th 16x strobe, and the first one comes on the 16th 16x strobe after reset.
- R6: After a write to either divisor byte or to the prescale code, the 16x period in progress completes with the old settings. The new settings take effect from the first terminal cycle after the write.
- R7: `tst_out` is held low while `tst_en` is low, and is equal to the 16x strobe in every cycle while `tst_en` is high.
- R8: When prescale × divisor is 1, the 16x strobe is high in every clock cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| div_lo_we | input | 1 | Write strobe for the divisor low byte |
| div_hi_we | input | 1 | Write strobe for the divisor high byte |
| div_wdata | input | 8 | Byte written to the selected divisor half |
| pre_we | input | 1 | Write strobe for the prescale code |
| pre_code | input | 2 | Prescale select code |
| tst_en | input | 1 | Enables the 16x strobe onto the test output |
| tick16 | output | 1 | One-cycle strobe at 16 times the bit rate |
| tick1 | output | 1 | One-cycle strobe at the bit rate |
| tst_out | output | 1 | Test copy of the 16x strobe |

## Verification
The hardest case to reach is a divisor write that lands in the middle of a period already under way. The old period has to finish at full length and the next one has to use the new value. The bench first lines up on a 16x strobe with a known divisor, waits a fixed number of cycles, and writes a new low byte. It then measures the next two intervals between strobes against the old and the new products. The bench also sweeps every prescale code against a set of divisors that includes 0, 1 and multi-byte values, and compares each measured period with the product it computes itself.

// File: rtl/baud_pkg.sv
package baud_pkg;
  localparam int BYTE_W = 8;
  localparam int DIV_W  = 2 * BYTE_W;
  localparam int PSEL_W = 2;
  localparam int PRE_W  = 4;
  localparam int OVS    = 16;
  localparam int OVS_W  = $clog2(OVS) + 1;
  localparam int PRE_MAX = 13;

  typedef logic [PSEL_W-1:0] psel_t;
  typedef logic [PRE_W-1:0]  pre_t;
  typedef logic [DIV_W-1:0]  div_t;

  function automatic pre_t prescale_of(input psel_t code);
    pre_t r;
    case (code)
      2'd0:    r = pre_t'(13);
      2'd1:    r = pre_t'(1);
      2'd2:    r = pre_t'(6);
      default: r = pre_t'(8);
    endcase
    return r;
  endfunction
endpackage

// File: rtl/baud_stage_counter.sv
module baud_stage_counter #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] limit,
  output logic         term
);
  logic [W-1:0] cnt;
  logic [W-1:0] last;

  assign last = limit - W'(1);
  assign term = en && (cnt >= last);

  always_ff @(posedge clk) begin
    if (!rst_n)
      cnt <= '0;
    else if (en)
      cnt <= term ? '0 : cnt + W'(1);
  end
endmodule

// File: rtl/baud_div_regs.sv
module baud_div_regs
  import baud_pkg::*;
#(
  parameter int RST_DIV = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lo_we,
  input  logic              hi_we,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              pre_we,
  input  psel_t             pre_code,
  input  logic              reload,
  output div_t              act_div,
  output pre_t              act_pre
);
  div_t  sh_div;
  psel_t sh_psel;
  div_t  run_div;
  psel_t run_psel;
  logic [1:0] lane_we;

  assign lane_we = {hi_we, lo_we};

  for (genvar g = 0; g < 2; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (!rst_n)
        sh_div[g*BYTE_W +: BYTE_W] <= BYTE_W'(RST_DIV >> (g*BYTE_W));
      else if (lane_we[g])
        sh_div[g*BYTE_W +: BYTE_W] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_psel  <= '0;
      run_psel <= '0;
      run_div  <= DIV_W'(RST_DIV);
    end else begin
      if (pre_we) sh_psel <= pre_code;
      if (reload) begin
        run_psel <= sh_psel;
        run_div  <= sh_div;
      end
    end
  end

  assign act_div = (run_div == '0) ? DIV_W'(1) : run_div;
  assign act_pre = prescale_of(run_psel);
endmodule

// File: rtl/baud_clock_gen.sv
module baud_clock_gen
  import baud_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        div_lo_we,
  input  logic        div_hi_we,
  input  logic [7:0]  div_wdata,
  input  logic        pre_we,
  input  logic [1:0]  pre_code,
  input  logic        tst_en,
  output logic        tick16,
  output logic        tick1,
  output logic        tst_out
);
  div_t act_div;
  pre_t act_pre;
  logic pre_term;
  logic div_term;
  logic bit_term;

  baud_div_regs u_regs (
    .clk(clk), .rst_n(rst_n),
    .lo_we(div_lo_we), .hi_we(div_hi_we), .wdata(div_wdata),
    .pre_we(pre_we), .pre_code(pre_code),
    .reload(div_term),
    .act_div(act_div), .act_pre(act_pre)
  );

  baud_stage_counter #(.W(PRE_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .en(1'b1), .limit(act_pre), .term(pre_term)
  );

  baud_stage_counter #(.W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .en(pre_term), .limit(act_div), .term(div_term)
  );

  baud_stage_counter #(.W(OVS_W)) u_bit (
    .clk(clk), .rst_n(rst_n), .en(div_term), .limit(OVS_W'(OVS)), .term(bit_term)
  );

  assign tick16  = div_term;
  assign tick1   = bit_term;
  assign tst_out = tst_en & div_term;
endmodule

// File: rtl/baud_clock_gen_chk.sv
module baud_clock_gen_chk
  import baud_pkg::*;
(
  input logic clk,
  input logic rst_n,
  input logic tick16,
  input logic tick1,
  input logic tst_en,
  input logic tst_out
);
  localparam int MAX_GAP = PRE_MAX * ((1 << DIV_W) - 1);
  localparam int GAP_W = $clog2(MAX_GAP) + 2;

  logic [GAP_W-1:0] gap;
  logic [OVS_W-1:0] n16;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap <= '0;
      n16 <= '0;
    end else begin
      gap <= tick16 ? '0 : gap + GAP_W'(1);
      if (tick1) n16 <= '0;
      else if (tick16) n16 <= n16 + OVS_W'(1);
    end
  end

  AST_BIT_WITH_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    tick1 |-> tick16); // R5
  AST_BIT_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    tick1 |-> (n16 == OVS_W'(OVS - 1))); // R5
  AST_BIT_NOT_LATE: assert property (@(posedge clk) disable iff (!rst_n)
    (tick16 && !tick1) |-> (n16 < OVS_W'(OVS - 1))); // R5
  AST_BIT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    tick1 |=> !tick1); // R5
  AST_TEST_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !tst_en |-> !tst_out); // R7
  AST_PERIOD_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    gap < GAP_W'(MAX_GAP)); // R3
endmodule

bind baud_clock_gen baud_clock_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick16(tick16), .tick1(tick1),
  .tst_en(tst_en), .tst_out(tst_out)
);

// File: tb/baud_clock_gen_test.sv
`timescale 1ns/1ps
module baud_clock_gen_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic div_lo_we = 1'b0, div_hi_we = 1'b0, pre_we = 1'b0, tst_en = 1'b0;
  logic [7:0] div_wdata = '0;
  logic [1:0] pre_code = '0;
  logic tick16, tick1, tst_out;

  int compared = 0;
  int mismatched = 0;
  int cyc = 0;
  localparam int WAIT_LIM = 20000;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  baud_clock_gen uut (
    .clk(clk), .rst_n(rst_n), .div_lo_we(div_lo_we), .div_hi_we(div_hi_we),
    .div_wdata(div_wdata), .pre_we(pre_we), .pre_code(pre_code),
    .tst_en(tst_en), .tick16(tick16), .tick1(tick1), .tst_out(tst_out)
  );

  function automatic int pre_val(input int code);
    case (code)
      0: return 13;
      1: return 1;
      2: return 6;
      default: return 8;
    endcase
  endfunction

  task automatic check(input string req, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input int which, input int d);
    div_wdata = 8'(d);
    pre_code  = 2'(d);
    div_lo_we = (which == 0);
    div_hi_we = (which == 1);
    pre_we    = (which == 2);
    @(negedge clk);
    div_lo_we = 1'b0; div_hi_we = 1'b0; pre_we = 1'b0;
  endtask

  task automatic cfg(input int code, input int dv);
    wr(0, dv & 255);
    wr(1, (dv >> 8) & 255);
    wr(2, code);
  endtask

  task automatic wait_tick(output int t);
    int guard = 0;
    do begin
      @(negedge clk);
      guard++;
    end while (!tick16 && guard < WAIT_LIM);
    if (!tick16) begin
      mismatched++;
      $display("FAIL timeout waiting for 16x strobe");
    end
    t = cyc;
  endtask

  initial begin
    #1900000;
    mismatched++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    int t0, t1, t2, t3, c0, n, bad;
    int divs [7] = '{0, 1, 2, 3, 7, 256, 300};
    // R1: outputs low during reset
    bad = 0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      if (tick16 || tick1 || tst_out) bad++;
    end
    check("R1 outputs low in reset", bad, 0);
    rst_n = 1'b1;
    c0 = cyc;
    wait_tick(t0);
    check("R1 first 16x strobe cycle", t0 - c0 + 1, 13);
    wait_tick(t1);
    check("R1 default period 13", t1 - t0, 13);

    // R2 R3 R4: sweep prescale codes against divisors
    for (int c = 0; c < 4; c++) begin
      for (int k = 0; k < 7; k++) begin
        cfg(c, divs[k]);
        wait_tick(t0);
        wait_tick(t1);
        check($sformatf("R2/R3/R4 code %0d div %0d", c, divs[k]), t1 - t0,
              pre_val(c) * ((divs[k] == 0) ? 1 : divs[k]));
      end
    end

    // R8: continuous strobe at product 1
    cfg(1, 1);
    wait_tick(t0);
    bad = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (!tick16) bad++;
    end
    check("R8 strobe every cycle", bad, 0);

    // R5: bit strobe every 16th sample strobe
    cfg(1, 2);
    wait_tick(t0);
    n = 0;
    do begin @(negedge clk); n++; end while (!tick1 && n < 200);
    t0 = cyc;
    n = 0; bad = 0;
    do begin
      @(negedge clk);
      if (tick1 && !tick16) bad++;
      if (tick16) n++;
    end while (!tick1);
    t1 = cyc;
    check("R5 strobes per bit", n, 16);
    check("R5 bit period", t1 - t0, 32);
    check("R5 bit only with sample", bad, 0);

    // R6: mid-period write keeps current period
    cfg(1, 10);
    wait_tick(t0);
    wait_tick(t1);
    check("R6 steady period", t1 - t0, 10);
    @(negedge clk); @(negedge clk); @(negedge clk);
    wr(0, 3);
    wait_tick(t2);
    check("R6 old period completes", t2 - t1, 10);
    wait_tick(t3);
    check("R6 new period used", t3 - t2, 3);
    // R6: prescale change mid-period
    @(negedge clk);
    wr(2, 2);
    wait_tick(t0);
    check("R6 old prescale completes", t0 - t3, 3);
    wait_tick(t1);
    check("R6 new prescale used", t1 - t0, 18);

    // R7: test output gating
    tst_en = 1'b0;
    bad = 0; n = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (tick16) n++;
      if (tst_out) bad++;
    end
    check("R7 gated low while disabled", bad, 0);
    check("R7 strobes present while disabled", (n > 0) ? 1 : 0, 1);
    tst_en = 1'b1;
    bad = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (tst_out != tick16) bad++;
    end
    check("R7 follows strobe when enabled", bad, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule